// File: doc/BRIEF.md
# Count-Register Conditional Branch Unit

This block resolves one branch-through-counter instruction per valid strobe. It receives a 32-bit instruction word, the address of that instruction, a 32-bit condition register, and the current count and link register values. It checks that the word is this branch, then evaluates the five-bit option code. The code can ask for a counter test, a condition test, both, or neither. The counter test first decrements the count and then checks the new count against zero. The condition test compares one condition-register bit, chosen by a five-bit index, against a required value.

All outputs are registered and update on the clock edge where `valid_i` is high. They give the taken decision, the target, the next count and link values, an illegal-instruction flag and the two hint bits. The target is the incoming count with its two low bits cleared. The surrounding core writes `ctr_o` and `lr_o` back to its architectural registers. The condition register is never produced by this block, so it cannot be changed.

Bits are numbered here with 0 as the most significant bit, so instruction bit k is `instr_i[31-k]`. The option code BO occupies `instr_i[25:21]`. BO bit 0 is `instr_i[25]` and BO bit 4 is `instr_i[21]`.

Top module: `ctr_branch_unit`

## Requirements
- R1: A word is legal only when `instr_i[31:26]` equals 19 and `instr_i[10:1]` equals 528. For any other word, `illegal_o` is 1, `taken_o` is 0, `ctr_o` equals the incoming count and `lr_o` equals the incoming link value.
- R2: `target_o` equals the incoming count with bits [1:0] replaced by zero. The value before any decrement is used.
- R3: When the link bit `instr_i[0]` is 1, `lr_o` is `pc_i + 4`. When it is 0, `lr_o` equals `lr_i`.
- R4: When BO bit 2 (`instr_i[23]`) is 0, `ctr_o` is `ctr_i - 1` modulo 2^32, so a count of zero becomes all ones. When BO bit 2 is 1, `ctr_o` equals `ctr_i`.
- R5: When BO bit 2 is 0, the counter test is applied to the decremented count. If BO bit 3 (`instr_i[22]`) is 0, the test passes when that count is non-zero. If BO bit 3 is 1, it passes when that count is zero. When BO bit 2 is 1, the counter test always passes.
- R6: When BO bit 0 (`instr_i[25]`) is 0, the condition test passes only if the condition bit equals BO bit 1 (`instr_i[24]`). The condition bit is `cr_i[31-BI]`, where BI is `instr_i[20:16]`. When BO bit 0 is 1, the condition test always passes.
- R7: `taken_o` is 1 exactly when a legal word passes both the counter test and the condition test. Every option code with BO bits 0 and 2 both set is taken unconditionally.
- R8: `bh_o` carries `instr_i[12:11]`. Its value never changes `taken_o`, `ctr_o`, `lr_o` or `target_o`.
- R9: All outputs change only on a rising edge where `valid_i` is 1, and `done_o` is then 1 for one cycle. On an edge with `valid_i` at 0, every output other than `done_o` holds its value.
- R10: Reset is synchronous and active low. It sets every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Evaluate the presented instruction on this edge |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the instruction |
| cr_i | input | 32 | Condition register |
| ctr_i | input | 32 | Current count register |
| lr_i | input | 32 | Current link register |
| done_o | output | 1 | One-cycle pulse: outputs hold a new result |
| taken_o | output | 1 | Branch is taken |
| illegal_o | output | 1 | Word is not this branch instruction |
| target_o | output | 32 | Word-aligned branch target |
| ctr_o | output | 32 | Count register value to write back |
| lr_o | output | 32 | Link register value to write back |
| bh_o | output | 2 | Hint field, passed through |

## Verification
The bench targets the counter wrap. A count of zero decremented under a "non-zero" test must be taken and leave all ones. A design that compared the old count, or saturated it, would report not-taken or leave zero behind. The bench also sets the selected condition bit at both ends of the register (BI of 0 and 31); reversed bit numbering would pick the wrong bit and invert the decision. Illegal words carrying a decrementing option code and the link bit check that nothing is written back, and a design that did not gate on legality would return a decremented count or a fresh link value. Hint variations and idle cycles with changed inputs expose any hint leaking into the decision and any output that moves without a strobe.

// File: rtl/cbu_pkg.sv
// Package: shared constants and types for the count-register branch unit.
// Assumes 32-bit instruction words with bit 0 of the field layout being
// the most significant bit of the word.
package cbu_pkg;
    localparam int INSTR_W  = 32;
    localparam logic [5:0] OPC_PRIMARY = 6'd19;
    localparam logic [9:0] OPC_EXT     = 10'd528;

    // Meaning of the two hint bits (informational only)
    typedef enum logic [1:0] {
        HINT_REPEAT = 2'b00,
        HINT_RSV_A  = 2'b01,
        HINT_RSV_B  = 2'b10,
        HINT_UNPRED = 2'b11
    } cbu_hint_e;

    // Decoded view of one instruction word
    typedef struct packed {
        logic       legal;
        logic [4:0] opt;      // option code, opt[4] is field bit 0
        logic [4:0] sel;      // condition bit index, MSB-first numbering
        cbu_hint_e  hint;
        logic       link;
    } cbu_fields_t;
endpackage

// File: rtl/cbu_decode.sv
// Module: cbu_decode
// Splits an instruction word into its fields and flags whether the word is
// the count-register branch. Purely combinational.
module cbu_decode
    import cbu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output cbu_fields_t        fields
);
    logic [5:0] primary;
    logic [9:0] extended;

    // Extract opcode fields and build the decoded struct
    always_comb begin
        primary       = instr[31:26];
        extended      = instr[10:1];
        fields.legal  = (primary == OPC_PRIMARY) && (extended == OPC_EXT);
        fields.opt    = instr[25:21];
        fields.sel    = instr[20:16];
        fields.hint   = cbu_hint_e'(instr[12:11]);
        fields.link   = instr[0];
    end
endmodule

// File: rtl/cbu_ctr_eval.sv
// Module: cbu_ctr_eval
// Computes the next count value and the counter test result from the
// option code. Assumes opt[2] (field bit 2) disables the decrement and
// opt[1] (field bit 3) chooses the zero / non-zero test. Wraps modulo 2^W.
module cbu_ctr_eval #(
    parameter int W = 32
) (
    input  logic [W-1:0] ctr,
    input  logic [4:0]   opt,
    output logic [W-1:0] ctr_next,
    output logic         ctr_pass
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] dec;
    logic         dec_zero;

    // Decrement, choose next value, and apply the selected zero test
    always_comb begin
        dec      = ctr - ONE;
        dec_zero = (dec == '0);
        ctr_next = opt[2] ? ctr : dec;
        ctr_pass = opt[2] | (opt[1] ? dec_zero : !dec_zero);
    end
endmodule

// File: rtl/cbu_cond_eval.sv
// Module: cbu_cond_eval
// Selects one condition-register bit by an MSB-first index and compares it
// with the required sense. Assumes CR_W is a power of two matching the
// index width.
module cbu_cond_eval #(
    parameter int CR_W = 32
) (
    input  logic [CR_W-1:0]         cr,
    input  logic [$clog2(CR_W)-1:0] sel,
    input  logic [4:0]              opt,
    output logic                    cond_pass
);
    logic [CR_W-1:0] cr_msb0;
    logic            bit_val;

    // Reverse the register so index 0 addresses the most significant bit
    for (genvar g = 0; g < CR_W; g++) begin : g_rev
        assign cr_msb0[g] = cr[CR_W-1-g];
    end

    // Pick the bit and test it unless the option code ignores the condition
    always_comb begin
        bit_val   = cr_msb0[sel];
        cond_pass = opt[4] | (bit_val == opt[3]);
    end
endmodule

// File: rtl/ctr_branch_unit.sv
// Module: ctr_branch_unit
// Resolves one branch-through-count instruction per valid strobe and
// registers taken flag, target, next count, next link and hint bits.
// Assumes the caller writes ctr_o / lr_o back to its own registers.
module ctr_branch_unit
    import cbu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [31:0]       instr_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [CR_W-1:0]   cr_i,
    input  logic [XLEN-1:0]   ctr_i,
    input  logic [XLEN-1:0]   lr_i,
    output logic              done_o,
    output logic              taken_o,
    output logic              illegal_o,
    output logic [XLEN-1:0]   target_o,
    output logic [XLEN-1:0]   ctr_o,
    output logic [XLEN-1:0]   lr_o,
    output logic [1:0]        bh_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    cbu_fields_t     fld;
    logic [XLEN-1:0] ctr_nx;
    logic            ctr_ok;
    logic            cond_ok;
    logic            take_d;
    logic [XLEN-1:0] ctr_d;
    logic [XLEN-1:0] lr_d;
    logic [XLEN-1:0] tgt_d;

    cbu_decode u_dec (
        .instr  (instr_i),
        .fields (fld)
    );

    cbu_ctr_eval #(.W(XLEN)) u_ctr (
        .ctr      (ctr_i),
        .opt      (fld.opt),
        .ctr_next (ctr_nx),
        .ctr_pass (ctr_ok)
    );

    cbu_cond_eval #(.CR_W(CR_W)) u_cond (
        .cr        (cr_i),
        .sel       (fld.sel),
        .opt       (fld.opt),
        .cond_pass (cond_ok)
    );

    // Combine tests and gate every write-back on legality
    always_comb begin
        take_d = fld.legal & ctr_ok & cond_ok;
        ctr_d  = fld.legal ? ctr_nx : ctr_i;
        lr_d   = (fld.legal && fld.link) ? (pc_i + STEP) : lr_i;
        tgt_d  = {ctr_i[XLEN-1:2], 2'b00};
    end

    // Result registers: load on strobe, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            taken_o   <= 1'b0;
            illegal_o <= 1'b0;
            target_o  <= '0;
            ctr_o     <= '0;
            lr_o      <= '0;
            bh_o      <= 2'b00;
        end else begin
            done_o <= valid_i;
            if (valid_i) begin
                taken_o   <= take_d;
                illegal_o <= !fld.legal;
                target_o  <= tgt_d;
                ctr_o     <= ctr_d;
                lr_o      <= lr_d;
                bh_o      <= fld.hint;
            end
        end
    end

    // R1: an illegal result is never a taken branch
    p_illegal_not_taken_r1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !taken_o);

    // R2: target follows the incoming count, low bits cleared
    p_target_from_ctr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (target_o[XLEN-1:2] == $past(ctr_i[XLEN-1:2])) && (target_o[1:0] == 2'b00));

    // R3: link register untouched when the link bit is clear
    p_lr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !instr_i[0]) |=> (lr_o == $past(lr_i)));

    // R4: count untouched when the option code disables decrementing
    p_ctr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i[23]) |=> (ctr_o == $past(ctr_i)));

    // R7: both-ignore option codes on a legal word always branch
    p_always_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i[31:26] == 6'd19 && instr_i[10:1] == 10'd528
         && instr_i[25] && instr_i[23]) |=> taken_o);

    // R9: outputs hold between strobes
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(taken_o) && $stable(ctr_o) && $stable(lr_o) && !done_o));
endmodule

// File: tb/ctr_branch_unit_tb.sv
// Directed bench: one task per scenario, each checking against an
// independent behavioural model of the requirements.
module ctr_branch_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0, pc_i = '0, cr_i = '0, ctr_i = '0, lr_i = '0;
    logic        done_o, taken_o, illegal_o;
    logic [31:0] target_o, ctr_o, lr_o;
    logic [1:0]  bh_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    ctr_branch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
        .pc_i(pc_i), .cr_i(cr_i), .ctr_i(ctr_i), .lr_i(lr_i),
        .done_o(done_o), .taken_o(taken_o), .illegal_o(illegal_o),
        .target_o(target_o), .ctr_o(ctr_o), .lr_o(lr_o), .bh_o(bh_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic [4:0] bo, input logic [4:0] bi,
                                        input logic [1:0] bh, input logic lk);
        return {6'd19, bo, bi, 3'b000, bh, 10'd528, lk};
    endfunction

    // Present one word for one edge, then compare with the model
    task automatic run(input string req, input logic [31:0] ins, input logic [31:0] pc,
                       input logic [31:0] cr, input logic [31:0] ctr, input logic [31:0] lr);
        logic        legal, dodec, cpass, bpass, exp_take;
        logic [31:0] nctr, nlr;
        legal = (ins[31:26] == 6'd19) && (ins[10:1] == 10'd528);
        dodec = legal && (ins[23] == 1'b0);
        nctr  = dodec ? ctr - 32'd1 : ctr;
        if (ins[23]) cpass = 1'b1;
        else if (ins[22]) cpass = ((ctr - 32'd1) == 0);
        else cpass = ((ctr - 32'd1) != 0);
        bpass    = ins[25] ? 1'b1 : (cr[31 - ins[20:16]] == ins[24]);
        exp_take = legal && cpass && bpass;
        nlr      = (legal && ins[0]) ? pc + 32'd4 : lr;
        @(negedge clk);
        valid_i = 1'b1; instr_i = ins; pc_i = pc; cr_i = cr; ctr_i = ctr; lr_i = lr;
        @(negedge clk);
        valid_i = 1'b0;
        chk(req, "done", {31'd0, done_o}, 32'd1);
        chk(req, "taken", {31'd0, taken_o}, {31'd0, exp_take});
        chk(req, "illegal", {31'd0, illegal_o}, {31'd0, !legal});
        chk(req, "target", target_o, {ctr[31:2], 2'b00});
        chk(req, "ctr", ctr_o, nctr);
        chk(req, "lr", lr_o, nlr);
        chk(req, "bh", {30'd0, bh_o}, {30'd0, ins[12:11]});
    endtask

    task automatic t_reset;
        chk("R10", "done", {31'd0, done_o}, 32'd0);
        chk("R10", "taken", {31'd0, taken_o}, 32'd0);
        chk("R10", "ctr", ctr_o, 32'd0);
        chk("R10", "lr", lr_o, 32'd0);
        chk("R10", "target", target_o, 32'd0);
    endtask

    task automatic t_always;   // R7 R2 R3 R4
        run("R7", enc(5'b10100, 5'd3, 2'b00, 1'b1), 32'h0000_1000, 32'h0, 32'h1234_567F, 32'hAAAA_0000);
        chk("R2", "target literal", target_o, 32'h1234_567C);
        chk("R3", "lr literal", lr_o, 32'h0000_1004);
        chk("R4", "ctr literal", ctr_o, 32'h1234_567F);
        run("R7", enc(5'b11111, 5'd9, 2'b00, 1'b0), 32'h40, 32'hFFFF_FFFF, 32'h8, 32'h77);
        chk("R3", "lr unchanged", lr_o, 32'h77);
    endtask

    task automatic t_condition; // R6, both ends of the register
        run("R6", enc(5'b00100, 5'd0, 2'b00, 1'b0), 32'h0, 32'h7FFF_FFFF, 32'h10, 32'h0);
        chk("R6", "bit0 clear taken", {31'd0, taken_o}, 32'd1);
        run("R6", enc(5'b00100, 5'd0, 2'b00, 1'b0), 32'h0, 32'h8000_0000, 32'h10, 32'h0);
        chk("R6", "bit0 set not taken", {31'd0, taken_o}, 32'd0);
        run("R6", enc(5'b01100, 5'd31, 2'b00, 1'b1), 32'h200, 32'h0000_0001, 32'h10, 32'h0);
        chk("R6", "bit31 set taken", {31'd0, taken_o}, 32'd1);
        run("R6", enc(5'b01100, 5'd31, 2'b00, 1'b0), 32'h200, 32'hFFFF_FFFE, 32'h10, 32'h0);
        chk("R6", "bit31 clear not taken", {31'd0, taken_o}, 32'd0);
    endtask

    task automatic t_counter;   // R5 R4
        run("R5", enc(5'b10000, 5'd0, 2'b00, 1'b0), 32'h0, 32'h0, 32'd5, 32'h0);
        chk("R4", "dec literal", ctr_o, 32'd4);
        run("R5", enc(5'b10000, 5'd0, 2'b00, 1'b0), 32'h0, 32'h0, 32'd1, 32'h0);
        chk("R5", "nz test on 1", {31'd0, taken_o}, 32'd0);
        run("R5", enc(5'b10010, 5'd0, 2'b00, 1'b0), 32'h0, 32'h0, 32'd1, 32'h0);
        chk("R5", "zero test on 1", {31'd0, taken_o}, 32'd1);
        run("R5", enc(5'b10010, 5'd0, 2'b00, 1'b0), 32'h0, 32'h0, 32'd7, 32'h0);
    endtask

    task automatic t_wrap;      // R4 R5 wrap
        run("R4", enc(5'b10000, 5'd0, 2'b00, 1'b0), 32'h0, 32'h0, 32'd0, 32'h0);
        chk("R4", "wrap value", ctr_o, 32'hFFFF_FFFF);
        chk("R5", "wrap nz taken", {31'd0, taken_o}, 32'd1);
        run("R5", enc(5'b10010, 5'd0, 2'b00, 1'b0), 32'h0, 32'h0, 32'd0, 32'h0);
        chk("R5", "wrap zero test", {31'd0, taken_o}, 32'd0);
    endtask

    task automatic t_combined;  // R7 counter AND condition
        run("R7", enc(5'b00000, 5'd2, 2'b00, 1'b1), 32'h300, 32'h0, 32'd3, 32'h5);
        chk("R7", "both pass", {31'd0, taken_o}, 32'd1);
        run("R7", enc(5'b00000, 5'd2, 2'b00, 1'b0), 32'h300, 32'h2000_0000, 32'd3, 32'h5);
        chk("R7", "cond fails", {31'd0, taken_o}, 32'd0);
        chk("R4", "still decremented", ctr_o, 32'd2);
        run("R7", enc(5'b01010, 5'd4, 2'b00, 1'b0), 32'h0, 32'h0800_0000, 32'd1, 32'h0);
        chk("R7", "zero and true", {31'd0, taken_o}, 32'd1);
        run("R7", enc(5'b01010, 5'd4, 2'b00, 1'b0), 32'h0, 32'h0800_0000, 32'd2, 32'h0);
        chk("R7", "count fails", {31'd0, taken_o}, 32'd0);
    endtask

    task automatic t_illegal;   // R1
        logic [31:0] w;
        w = enc(5'b10000, 5'd0, 2'b00, 1'b1);
        w[31:26] = 6'd18;
        run("R1", w, 32'h100, 32'h0, 32'd9, 32'hBEEF);
        chk("R1", "ctr kept", ctr_o, 32'd9);
        chk("R1", "lr kept", lr_o, 32'hBEEF);
        w = enc(5'b10100, 5'd0, 2'b00, 1'b1);
        w[10:1] = 10'd16;
        run("R1", w, 32'h100, 32'h0, 32'd9, 32'hBEEF);
        chk("R1", "illegal flag", {31'd0, illegal_o}, 32'd1);
        chk("R1", "not taken", {31'd0, taken_o}, 32'd0);
    endtask

    task automatic t_hint;      // R8
        for (int h = 0; h < 4; h++) begin
            run("R8", enc(5'b00100, 5'd1, h[1:0], 1'b1), 32'h50, 32'h0, 32'd6, 32'h1);
            chk("R8", "taken unaffected", {31'd0, taken_o}, 32'd1);
            chk("R8", "lr unaffected", lr_o, 32'h54);
        end
    endtask

    task automatic t_idle;      // R9
        run("R9", enc(5'b10000, 5'd0, 2'b01, 1'b1), 32'h80, 32'h0, 32'd20, 32'h0);
        @(negedge clk);
        instr_i = enc(5'b10010, 5'd0, 2'b11, 1'b0); ctr_i = 32'd1; lr_i = 32'h99; pc_i = 32'h0;
        @(negedge clk);
        @(negedge clk);
        chk("R9", "done low", {31'd0, done_o}, 32'd0);
        chk("R9", "ctr held", ctr_o, 32'd19);
        chk("R9", "lr held", lr_o, 32'h84);
        chk("R9", "taken held", {31'd0, taken_o}, 32'd1);
        chk("R9", "bh held", {30'd0, bh_o}, 32'd1);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_always();
        t_condition();
        t_counter();
        t_wrap();
        t_combined();
        t_illegal();
        t_hint();
        t_idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule